// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block sits between a processor core and its memory port. The core hands it one memory-update request at a time: an operation kind, a lock-prefix flag, a byte address, an operand length and a write operand. The block turns the request into a series of 32-bit bus transfers with byte enables. It reads the operand, works out the new value for the kinds that write, and writes it back. While it does this it drives an active-low lock output, so that no other bus master can get onto the bus between the transfers of one update.

An operand that crosses a 4-byte boundary is split into two aligned transfers, lower word first. The lock covers every transfer of the read phase and of the write phase, and it is held through memory stalls. Exchanges, interrupt acknowledges, task busy-bit updates, descriptor loads and page-entry flag updates always lock. A plain read-modify-write locks only when its prefix flag is set.

When the sequence ends, the block pulses `done` and presents the zero-extended operand that it read.

Top module: `atomic_bus_sequencer`

## Requirements
- R1: A request is taken on a clock edge where `reqValid` and `reqReady` are both high. `reqReady` is high only while the block is idle, so a request presented while a sequence is running is ignored. After reset the block is idle, with `lockN` high, `memReq` low and `done` low.
- R2: For a locked sequence, `lockN` goes low one cycle before the first `memReq` cycle. It stays low through the cycle after the final transfer is accepted, and in that cycle `done` pulses with `rdData` valid. `lockN` is high again in the following cycle.
- R3: While `memReq` is high and `memReady` is low, `memReq`, `memAddr`, `memBe` and `memWe` hold their values, and a low `lockN` stays low. Between the transfers of one locked sequence `lockN` never returns high, so it falls exactly once per sequence.
- R4: `reqLen` codes 0, 1 and 2 select 1, 2 and 4 bytes. Code 3 also selects 4 bytes. The operand occupies byte lanes starting at `reqAddr[1:0]`, where `memBe` bit i enables byte i of the word. When the operand spills past lane 3, the block makes two transfers: first to the word at the request, then to the next word. `memAddr` is always word-aligned.
- R5: Kind codes are 0 read-modify-write, 1 exchange, 2 interrupt acknowledge, 3 task busy-bit set, 4 descriptor load and 5 page-entry flag update. Kinds 1 to 5 lock whatever `reqPrefix` is. Kind 0, and the unused codes 6 and 7 that behave as kind 0, lock only when `reqPrefix` is 1.
- R6: Read-modify-write reads all operand words and then writes back operand plus `reqWdata`, truncated to the operand length. `rdData` returns the old value.
- R7: Exchange reads the old operand, writes `reqWdata` in its place and returns the old value.
- R8: Task busy-bit set reads the operand at the given address and length and writes back old OR `reqWdata`. Page-entry flag update does the same on a full word, with `reqAddr[1:0]` and `reqLen` ignored, and raises `memNoCache` on its transfers.
- R9: Interrupt acknowledge performs only read transfers, on the given address and length, and writes nothing.
- R10: Descriptor load ignores `reqAddr[1:0]` and `reqLen`. It reads the word at the request with all enables, then the next word, writes nothing, and returns `{second word, first word}`.
- R11: For every kind other than descriptor load, `rdData` holds the operand bytes, lowest address in bits 7:0, with all higher bits zero.
- R12: A read-modify-write without prefix runs the same transfers with `lockN` high for the whole sequence.
- R13: The second word address wraps modulo 2^ADDR_W when the first transfer is to the highest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle; request taken when both high |
| reqKind | input | 3 | Operation kind code |
| reqPrefix | input | 1 | Lock-prefix flag |
| reqAddr | input | ADDR_W | Operand byte address |
| reqLen | input | 2 | Operand length code |
| reqWdata | input | 32 | Write operand or set mask |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rdData | output | 64 | Operand read by the sequence |
| lockN | output | 1 | Bus lock, active low |
| memReq | output | 1 | Transfer request |
| memWe | output | 1 | Transfer is a write |
| memAddr | output | ADDR_W | Word-aligned transfer address |
| memBe | output | 4 | Byte enables |
| memWdata | output | 32 | Write data, lane-aligned |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Transfer accepted this cycle |
| memNoCache | output | 1 | Transfer must bypass any page-table cache |

## Verification
The bench builds the block with ADDR_W = 12. A 4 KiB word-array memory model can then cover the whole address space. The model's stall length is set for each scenario, which exercises the lock hold under multi-cycle waits. The 12-bit space also lets one scenario place a misaligned operand in the top word so that its second transfer wraps to word 0. Lock low time, lock falls and the transfer log are counted at the ports and compared with transfer count × (stall + 1) + 2.

// File: rtl/atomic_seq_pkg.sv
package atomic_seq_pkg;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [2:0] {
    KIND_RMW      = 3'd0,
    KIND_SWAP     = 3'd1,
    KIND_INTACK   = 3'd2,
    KIND_TASKBUSY = 3'd3,
    KIND_DESCLOAD = 3'd4,
    KIND_PAGEFLAG = 3'd5
  } opKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic capture;
    logic wordSel;
    logic writePhase;
  } seqStrobe_t;

  // facts about the held request, datapath to control
  typedef struct packed {
    logic locked;
    logic twoWords;
    logic writes;
  } seqPlan_t;

endpackage

// File: rtl/atomic_seq_dpath.sv
module atomic_seq_dpath
  import atomic_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          reqKind,
  input  logic                reqPrefix,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqLen,
  input  logic [WORD_W-1:0]   reqWdata,
  input  seqStrobe_t          strobe,
  input  logic [WORD_W-1:0]   memRdata,
  output seqPlan_t            plan,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [WORD_BYTES-1:0] memBe,
  output logic [WORD_W-1:0]   memWdata,
  output logic                pageFlagOp,
  output logic [2*WORD_W-1:0] rdData
);

  localparam int WA_W   = ADDR_W - 2;
  localparam int DW     = 2 * WORD_W;
  localparam int SPAN_W = 2 * WORD_BYTES;

  opKind_t           kindQ;
  logic              prefixQ;
  logic [WA_W-1:0]   wordQ;
  logic [1:0]        offQ;
  logic [1:0]        lenQ;
  logic [WORD_W-1:0] wdataQ;
  logic [DW-1:0]     rawQ;

  logic              fixedWord;
  assign fixedWord = (reqKind == KIND_DESCLOAD) || (reqKind == KIND_PAGEFLAG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ   <= KIND_RMW;
      prefixQ <= 1'b0;
      wordQ   <= '0;
      offQ    <= '0;
      lenQ    <= '0;
      wdataQ  <= '0;
      rawQ    <= '0;
    end else if (strobe.load) begin
      kindQ   <= opKind_t'(reqKind);
      prefixQ <= reqPrefix;
      wordQ   <= reqAddr[ADDR_W-1:2];
      wdataQ  <= reqWdata;
      rawQ    <= '0;
      offQ    <= fixedWord ? 2'd0 : reqAddr[1:0];
      lenQ    <= fixedWord ? 2'd2 : reqLen;
    end else if (strobe.capture) begin
      if (strobe.wordSel) rawQ[DW-1:WORD_W] <= memRdata;
      else                rawQ[WORD_W-1:0]  <= memRdata;
    end
  end

  // byte mask of the operand before lane shift
  logic [SPAN_W-1:0] lenMask;
  always_comb begin
    unique case (lenQ)
      2'd0:    lenMask = 8'h01;
      2'd1:    lenMask = 8'h03;
      default: lenMask = 8'h0F;
    endcase
    if (kindQ == KIND_DESCLOAD) lenMask = 8'hFF;
  end

  logic [SPAN_W-1:0] span;
  assign span = lenMask << offQ;

  logic [DW-1:0] keepMask;
  for (genvar b = 0; b < SPAN_W; b++) begin : g_keep
    assign keepMask[b*8 +: 8] = {8{lenMask[b]}};
  end

  logic [DW-1:0] operand;
  assign operand = rawQ >> {offQ, 3'b000};
  assign rdData  = operand & keepMask;

  logic [WORD_W-1:0] oldVal;
  logic [WORD_W-1:0] newVal;
  assign oldVal = rdData[WORD_W-1:0];

  always_comb begin
    unique case (kindQ)
      KIND_SWAP:                    newVal = wdataQ;
      KIND_TASKBUSY, KIND_PAGEFLAG: newVal = oldVal | wdataQ;
      default:                      newVal = oldVal + wdataQ;
    endcase
  end

  logic [DW-1:0] laneData;
  assign laneData = {{WORD_W{1'b0}}, newVal} << {offQ, 3'b000};

  assign memBe    = strobe.wordSel ? span[SPAN_W-1:WORD_BYTES] : span[WORD_BYTES-1:0];
  assign memWdata = strobe.wordSel ? laneData[DW-1:WORD_W] : laneData[WORD_W-1:0];
  assign memAddr  = {wordQ + WA_W'(strobe.wordSel), 2'b00};

  assign plan.locked   = prefixQ || (kindQ inside {KIND_SWAP, KIND_INTACK, KIND_TASKBUSY,
                                                   KIND_DESCLOAD, KIND_PAGEFLAG});
  assign plan.twoWords = |span[SPAN_W-1:WORD_BYTES];
  assign plan.writes   = !(kindQ inside {KIND_INTACK, KIND_DESCLOAD});
  assign pageFlagOp    = (kindQ == KIND_PAGEFLAG);

  // R11: bytes above the operand never reach the result
  assert_result_zext_R11: assert property (@(posedge clk) disable iff (!rstN)
    (kindQ != KIND_DESCLOAD) |-> (rdData[DW-1:WORD_W] == '0));

endmodule

// File: rtl/atomic_seq_ctrl.sv
module atomic_seq_ctrl
  import atomic_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       memReady,
  input  seqPlan_t   plan,
  output logic       reqReady,
  output logic       memReq,
  output logic       memWe,
  output logic       lockN,
  output logic       done,
  output seqStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_XFER, ST_TAIL} seqState_t;

  seqState_t stateQ;
  logic      idxQ;
  logic      wrQ;
  logic      lastWord;

  assign lastWord = !plan.twoWords || idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= 1'b0;
      wrQ    <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: if (reqValid) begin
          stateQ <= ST_LEAD;
          idxQ   <= 1'b0;
          wrQ    <= 1'b0;
        end
        ST_LEAD: stateQ <= ST_XFER;
        ST_XFER: if (memReady) begin
          if (!lastWord) begin
            idxQ <= 1'b1;
          end else if (!wrQ && plan.writes) begin
            wrQ  <= 1'b1;
            idxQ <= 1'b0;
          end else begin
            stateQ <= ST_TAIL;
          end
        end
        ST_TAIL: stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (stateQ == ST_IDLE);
  assign memReq   = (stateQ == ST_XFER);
  assign memWe    = memReq && wrQ;
  assign done     = (stateQ == ST_TAIL);
  assign lockN    = !(plan.locked && (stateQ != ST_IDLE));

  always_comb begin
    strobe.load       = reqReady && reqValid;
    strobe.capture    = memReq && memReady && !wrQ;
    strobe.wordSel    = idxQ;
    strobe.writePhase = wrQ;
  end

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_lock_leads_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memReq) && plan.locked) |-> $past(!lockN));

  assert_done_ends_xfer_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memReq) |-> done);

  assert_release_after_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (lockN && reqReady));

  assert_lock_held_stall_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && !lockN) |=> (!lockN && memReq));

endmodule

// File: rtl/atomic_bus_sequencer.sv
module atomic_bus_sequencer
  import atomic_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [2:0]          reqKind,
  input  logic                reqPrefix,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [1:0]          reqLen,
  input  logic [31:0]         reqWdata,
  output logic                done,
  output logic [63:0]         rdData,
  output logic                lockN,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [3:0]          memBe,
  output logic [31:0]         memWdata,
  input  logic [31:0]         memRdata,
  input  logic                memReady,
  output logic                memNoCache
);

  seqStrobe_t strobe;
  seqPlan_t   plan;
  logic       pageFlagOp;

  atomic_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memReady (memReady),
    .plan     (plan),
    .reqReady (reqReady),
    .memReq   (memReq),
    .memWe    (memWe),
    .lockN    (lockN),
    .done     (done),
    .strobe   (strobe)
  );

  atomic_seq_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .reqKind    (reqKind),
    .reqPrefix  (reqPrefix),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqWdata   (reqWdata),
    .strobe     (strobe),
    .memRdata   (memRdata),
    .plan       (plan),
    .memAddr    (memAddr),
    .memBe      (memBe),
    .memWdata   (memWdata),
    .pageFlagOp (pageFlagOp),
    .rdData     (rdData)
  );

  assign memNoCache = memReq && pageFlagOp;

  assert_stall_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memBe) && $stable(memWe)));

  assert_lane_enabled_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBe != 4'd0 && memAddr[1:0] == 2'b00));

  assert_pageflag_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    memNoCache |-> !lockN);

endmodule

// File: tb/atomic_bus_sequencer_test.sv
`timescale 1ns/1ps
module atomic_bus_sequencer_test;

  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [2:0]    reqKind = '0;
  logic          reqPrefix = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqLen = '0;
  logic [31:0]   reqWdata = '0;
  logic          done;
  logic [63:0]   rdData;
  logic          lockN, memReq, memWe, memReady, memNoCache;
  logic [AW-1:0] memAddr;
  logic [3:0]    memBe;
  logic [31:0]   memWdata, memRdata;

  atomic_bus_sequencer #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqPrefix(reqPrefix), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqWdata(reqWdata), .done(done), .rdData(rdData), .lockN(lockN),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .memNoCache(memNoCache)
  );

  // memory model
  logic [31:0] mem [0:1023];
  int          waitCnt = 0;
  int          stallCfg = 0;
  logic        pokeEn = 1'b0;
  int          pokeIdx = 0;
  logic [31:0] pokeVal = '0;

  assign memReady = memReq && (waitCnt >= stallCfg);
  assign memRdata = mem[memAddr[11:2]];

  always @(posedge clk) begin
    if (pokeEn) mem[pokeIdx] <= pokeVal;
    if (memReq && memReady && memWe)
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[11:2]][b*8 +: 8] <= memWdata[b*8 +: 8];
    waitCnt <= (memReq && !memReady) ? waitCnt + 1 : 0;
  end

  // port monitor
  logic          monClr = 1'b0;
  int            reqCyc, lockLow, lockFalls, reqUnlocked, nLog;
  logic          prevLockN = 1'b1;
  logic [AW-1:0] logA [8];
  logic [3:0]    logB [8];
  logic          logW [8];
  logic          logN [8];

  always @(negedge clk) begin
    if (monClr) begin
      reqCyc = 0; lockLow = 0; lockFalls = 0; reqUnlocked = 0; nLog = 0;
    end else begin
      if (memReq) reqCyc++;
      if (!lockN) lockLow++;
      if (!lockN && prevLockN) lockFalls++;
      if (memReq && lockN) reqUnlocked++;
      if (memReq && memReady && nLog < 8) begin
        logA[nLog] = memAddr; logB[nLog] = memBe;
        logW[nLog] = memWe;   logN[nLog] = memNoCache;
        nLog++;
      end
    end
    prevLockN = lockN;
  end

  int tests = 0;
  int fails = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chkX(string tag, int i, logic [AW-1:0] a, logic [3:0] be, logic we, logic nc);
    chk($sformatf("%s transfer %0d {addr,be,we,nc}", tag, i),
        64'({logA[i], logB[i], logW[i], logN[i]}), 64'({a, be, we, nc}));
  endtask

  task automatic poke(int idx, logic [31:0] v);
    @(negedge clk); #1;
    pokeEn = 1'b1; pokeIdx = idx; pokeVal = v;
    @(negedge clk); #1;
    pokeEn = 1'b0;
  endtask

  task automatic startOp(logic [2:0] k, logic p, logic [AW-1:0] a, logic [1:0] l,
                         logic [31:0] wd, int stall);
    @(negedge clk); #1;
    monClr = 1'b1; stallCfg = stall;
    @(negedge clk); #1;
    monClr = 1'b0;
    reqValid = 1'b1; reqKind = k; reqPrefix = p; reqAddr = a; reqLen = l; reqWdata = wd;
    @(negedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output logic [63:0] rd);
    do @(negedge clk); while (!done);
    #1;
    rd = rdData;
  endtask

  task automatic lockCheck(string tag, int nX, int stall, logic locked);
    chk({tag, " log count"}, 64'(nLog), 64'(nX));
    chk({tag, " req cycles"}, 64'(reqCyc), 64'(nX * (stall + 1)));
    chk({tag, " lock low cycles"}, 64'(lockLow), locked ? 64'(nX * (stall + 1) + 2) : 64'd0);
    chk({tag, " lock falls"}, 64'(lockFalls), locked ? 64'd1 : 64'd0);
    if (locked) chk({tag, " req unlocked"}, 64'(reqUnlocked), 64'd0);
    @(negedge clk); #1;
    chk({tag, " R2 lock released after done"}, 64'(lockN), 64'd1);
  endtask

  task automatic testReset();
    chk("R1 reset reqReady", 64'(reqReady), 64'd1);
    chk("R1 reset lockN", 64'(lockN), 64'd1);
    chk("R1 reset memReq", 64'(memReq), 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);
  endtask

  task automatic testRmwAligned();
    logic [63:0] rd;
    poke('h100 >> 2, 32'h11223344);
    startOp(3'd0, 1'b1, 12'h100, 2'd2, 32'd5, 2);
    waitDone(rd);
    chk("R6 rmw old value", rd, 64'h11223344);
    chk("R6 rmw memory", 64'(mem['h100 >> 2]), 64'h11223349);
    chkX("R6", 0, 12'h100, 4'hF, 1'b0, 1'b0);
    chkX("R6", 1, 12'h100, 4'hF, 1'b1, 1'b0);
    lockCheck("R2 R5 rmw prefixed", 2, 2, 1'b1);
  endtask

  task automatic testRmwSplit();
    logic [63:0] rd;
    poke('h200 >> 2, 32'hAABBCCDD);
    poke('h204 >> 2, 32'h55667788);
    startOp(3'd0, 1'b1, 12'h202, 2'd2, 32'h01000001, 1);
    waitDone(rd);
    chk("R4 R11 split old value", rd, 64'h7788AABB);
    chk("R6 split low word", 64'(mem['h200 >> 2]), 64'hAABCCCDD);
    chk("R6 split high word", 64'(mem['h204 >> 2]), 64'h55667888);
    chkX("R4", 0, 12'h200, 4'hC, 1'b0, 1'b0);
    chkX("R4", 1, 12'h204, 4'h3, 1'b0, 1'b0);
    chkX("R4", 2, 12'h200, 4'hC, 1'b1, 1'b0);
    chkX("R4", 3, 12'h204, 4'h3, 1'b1, 1'b0);
    lockCheck("R3 split", 4, 1, 1'b1);
  endtask

  task automatic testRmwUnlocked();
    logic [63:0] rd;
    poke('h300 >> 2, 32'h0000FFFF);
    startOp(3'd0, 1'b0, 12'h300, 2'd1, 32'd1, 0);
    waitDone(rd);
    chk("R12 unprefixed old value", rd, 64'h0000FFFF);
    chk("R6 truncated sum", 64'(mem['h300 >> 2]), 64'h00000000);
    lockCheck("R12 unprefixed", 2, 0, 1'b0);
  endtask

  task automatic testSwap();
    logic [63:0] rd;
    poke('h400 >> 2, 32'h44332211);
    poke('h404 >> 2, 32'h88776655);
    startOp(3'd1, 1'b0, 12'h403, 2'd1, 32'h0000BEEF, 1);
    waitDone(rd);
    chk("R7 swap old value", rd, 64'h5544);
    chk("R7 swap low word", 64'(mem['h400 >> 2]), 64'hEF332211);
    chk("R7 swap high word", 64'(mem['h404 >> 2]), 64'h887766BE);
    chkX("R4", 0, 12'h400, 4'h8, 1'b0, 1'b0);
    chkX("R4", 1, 12'h404, 4'h1, 1'b0, 1'b0);
    lockCheck("R5 swap no prefix", 4, 1, 1'b1);
  endtask

  task automatic testIntAck();
    logic [63:0] rd;
    poke('h500 >> 2, 32'h00002A00);
    startOp(3'd2, 1'b0, 12'h501, 2'd0, 32'hFFFFFFFF, 3);
    waitDone(rd);
    chk("R9 ack id", rd, 64'h2A);
    chk("R9 memory untouched", 64'(mem['h500 >> 2]), 64'h00002A00);
    chkX("R9", 0, 12'h500, 4'h2, 1'b0, 1'b0);
    lockCheck("R9 ack", 1, 3, 1'b1);
  endtask

  task automatic testTaskBusy();
    logic [63:0] rd;
    poke('h604 >> 2, 32'h00008900);
    startOp(3'd3, 1'b0, 12'h605, 2'd0, 32'h02, 1);
    waitDone(rd);
    chk("R8 busy old value", rd, 64'h89);
    chk("R8 busy set", 64'(mem['h604 >> 2]), 64'h00008B00);
    chkX("R8", 0, 12'h604, 4'h2, 1'b0, 1'b0);
    chkX("R8", 1, 12'h604, 4'h2, 1'b1, 1'b0);
    lockCheck("R5 busy", 2, 1, 1'b1);
  endtask

  task automatic testPageFlag();
    logic [63:0] rd;
    poke('h708 >> 2, 32'h12340001);
    startOp(3'd5, 1'b0, 12'h70A, 2'd0, 32'h60, 2);
    waitDone(rd);
    chk("R8 page old value", rd, 64'h12340001);
    chk("R8 page flags set", 64'(mem['h708 >> 2]), 64'h12340061);
    chkX("R8", 0, 12'h708, 4'hF, 1'b0, 1'b1);
    chkX("R8", 1, 12'h708, 4'hF, 1'b1, 1'b1);
    lockCheck("R5 page", 2, 2, 1'b1);
  endtask

  task automatic testDescLoad();
    logic [63:0] rd;
    poke('h800 >> 2, 32'hCAFE0001);
    poke('h804 >> 2, 32'h00CF9A00);
    startOp(3'd4, 1'b0, 12'h803, 2'd0, 32'h0, 3);
    waitDone(rd);
    chk("R10 descriptor", rd, 64'h00CF9A00_CAFE0001);
    chkX("R10", 0, 12'h800, 4'hF, 1'b0, 1'b0);
    chkX("R10", 1, 12'h804, 4'hF, 1'b0, 1'b0);
    lockCheck("R10 descriptor", 2, 3, 1'b1);
  endtask

  task automatic testBusyIgnored();
    logic [63:0] rd;
    poke('h900 >> 2, 32'h01020304);
    poke('h904 >> 2, 32'hA5A5A5A5);
    startOp(3'd1, 1'b0, 12'h900, 2'd2, 32'h12345678, 4);
    for (int i = 0; i < 3; i++) begin
      reqValid = 1'b1; reqKind = 3'd0; reqPrefix = 1'b1;
      reqAddr = 12'h904; reqLen = 2'd2; reqWdata = 32'h77;
      @(negedge clk); #1;
      chk("R1 not ready while busy", 64'(reqReady), 64'd0);
    end
    reqValid = 1'b0;
    waitDone(rd);
    chk("R1 first op result", rd, 64'h01020304);
    chk("R1 swap written", 64'(mem['h900 >> 2]), 64'h12345678);
    lockCheck("R1 busy", 2, 4, 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 ignored request wrote nothing", 64'(mem['h904 >> 2]), 64'hA5A5A5A5);
    chk("R1 idle afterwards", 64'(reqReady), 64'd1);
  endtask

  task automatic testWrap();
    logic [63:0] rd;
    poke(1023, 32'h33221100);
    poke(0, 32'h77665544);
    startOp(3'd0, 1'b1, 12'hFFE, 2'd3, 32'h10, 0);
    waitDone(rd);
    chk("R13 wrap old value", rd, 64'h55443322);
    chk("R13 wrap top word", 64'(mem[1023]), 64'h33321100);
    chk("R13 wrap word zero", 64'(mem[0]), 64'h77665544);
    chkX("R13", 0, 12'hFFC, 4'hC, 1'b0, 1'b0);
    chkX("R13", 1, 12'h000, 4'h3, 1'b0, 1'b0);
    lockCheck("R4 len code 3", 4, 0, 1'b1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: sequence hung, actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      pokeEn = 1'b1; pokeIdx = i; pokeVal = '0;
      @(negedge clk);
    end
    pokeEn = 1'b0;
    #1;
    testReset();
    rstN = 1'b1;
    testRmwAligned();
    testRmwSplit();
    testRmwUnlocked();
    testSwap();
    testIntAck();
    testTaskBusy();
    testPageFlag();
    testDescLoad();
    testBusyIgnored();
    testWrap();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule